// File: doc/BRIEF.md
# Polled Single-Word SPI Transmitter

This block is one control register with a serial shifter behind it. Software loads a 16-bit word into the register, then sends it to an external SPI device without further help from software. The register holds the word, an enable marker and a launch/status bit. Software first writes the word with the launch bit clear, then writes the same value again with the launch bit set. The hardware then drives chip select low. It shifts the word out MSB first in SPI mode 0 on a serial clock divided down from the system clock. When the last bit has gone out, the hardware clears the launch bit. Software polls that same bit to learn when the transfer is done.

The serial clock runs at the system clock divided by the even parameter `CLK_DIV`. The default of 16 completes a word in 256 system cycles, far inside a 1 ms software polling budget at any usual system clock. Register bits above the enable marker are plain storage and have no effect on the engine.

Top module: `spi_word_launcher`

## Requirements
- R1: After reset the register reads all zeros, `cs_n` is 1, and `sclk` and `mosi` are 0.
- R2: A register write stores bits 15:0, bit 17 and every bit above 17. A write with bit 16 clear reads back exactly the written value.
- R3: A write with bit 16 = 1 and bit 17 = 1 while idle starts a transfer. From the next cycle, bit 16 reads 1 and `cs_n` is 0.
- R4: A write with bit 16 = 1 and bit 17 = 0 starts nothing. Bit 16 reads 0, `cs_n` stays 1, and `sclk` does not toggle.
- R5: During a transfer, exactly 16 rising edges of `sclk` occur. At those edges `mosi` carries the word loaded at launch, bit 15 first and bit 0 last, and `mosi` is stable across each rising edge.
- R6: While chip select is active, consecutive rising edges of `sclk` are `CLK_DIV` system cycles apart. `sclk` is 0 whenever `cs_n` is 1.
- R7: Bit 16 reads 1, and `cs_n` is 0, for exactly 16*`CLK_DIV` system cycles per transfer. After that, bit 16 reads 0 and `cs_n` is 1.
- R8: A write during a transfer neither restarts nor alters the word being shifted, whatever its bit 16. Its bits other than 16 are stored and read back after completion, and no second transfer follows.
- R9: The value of bits above 17 has no effect on the shifted word or on the transfer timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | REG_W | Value written to the register |
| rd_data | output | REG_W | Register read value; bit 16 is the busy status |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with `CLK_DIV` = 6, so each half period of the serial clock lasts three system cycles. That makes any off-by-one in the divider or the half-period counter visible in the measured busy length and in the edge spacing. At this divider a transfer takes 96 cycles, which allows many random words and random upper-bit values, plus mid-transfer writes, inside a short run. The default `REG_W` of 32 leaves fourteen storage bits above the enable marker to show that they are independent of the engine.

// File: rtl/spi_word_launcher.sv
module spi_word_launcher #(
  parameter int REG_W   = 32,
  parameter int CLK_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n
);
  localparam int WORD_W = 16;
  localparam int GO_BIT = 16;
  localparam int EN_BIT = 17;
  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = $clog2(HALF + 1);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [REG_W-1:0] GO_MASK = REG_W'(1) << GO_BIT;

  logic [REG_W-1:0]  store_q;
  logic              busy_q;
  logic              sclk_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] shift_q;

  wire start = wr_en & wr_data[GO_BIT] & wr_data[EN_BIT] & ~busy_q;
  wire tick  = busy_q && (div_q == DIV_W'(HALF - 1));
  wire last  = (bit_q == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else if (wr_en) store_q <= wr_data & ~GO_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      sclk_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      shift_q <= wr_data[WORD_W-1:0];
    end else if (busy_q) begin
      if (!tick) begin
        div_q <= div_q + DIV_W'(1);
      end else begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (last) begin
            busy_q <= 1'b0;
          end else begin
            bit_q   <= bit_q + BIT_W'(1);
            shift_q <= shift_q << 1;
          end
        end
      end
    end
  end

  assign rd_data = store_q | (busy_q ? GO_MASK : '0);
  assign sclk    = sclk_q;
  assign mosi    = busy_q & shift_q[WORD_W-1];
  assign cs_n    = ~busy_q;
endmodule

// File: rtl/spi_word_launcher_chk.sv
module spi_word_launcher_chk #(
  parameter int REG_W   = 32,
  parameter int CLK_DIV = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             sclk,
  input logic             mosi,
  input logic             cs_n
);
  logic [31:0] act_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_cnt <= '0;
    else if (!cs_n) act_cnt <= act_cnt + 32'd1;
    else act_cnt <= '0;
  end

  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[15:0] == $past(wr_data[15:0])));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[16] && wr_data[17] && cs_n) |=> (!cs_n && rd_data[16]));

  p_no_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[17] && cs_n) |=> cs_n);

  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && act_cnt != 0) |-> (act_cnt == 32'(16 * CLK_DIV)));
endmodule

bind spi_word_launcher spi_word_launcher_chk #(.REG_W(REG_W), .CLK_DIV(CLK_DIV)) u_chk (.*);

// File: tb/test_spi_word_launcher.sv
module test_spi_word_launcher;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 32;
  localparam int CLK_DIV    = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic             sclk, mosi, cs_n;

  int checks = 0;
  int errors = 0;

  spi_word_launcher #(.REG_W(REG_W), .CLK_DIV(CLK_DIV)) i_spi_word_launcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] cap;
  int          n_rise;
  int          gap_bad;
  time         last_rise;

  always @(posedge sclk) begin
    cap = {cap[14:0], mosi};
    if (n_rise > 0 && ($time - last_rise) != time'(CLK_DIV * CLK_PERIOD)) gap_bad++;
    last_rise = $time;
    n_rise++;
  end

  function automatic logic [REG_W-1:0] pack(logic [REG_W-19:0] up, logic en, logic go, logic [15:0] d);
    return {up, en, go, d};
  endfunction

  function automatic int exp_len();
    return 16 * CLK_DIV;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [REG_W-1:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic transfer(logic [REG_W-19:0] up, logic [15:0] d, bit mid, logic [15:0] d2, logic mid_go);
    int len;
    logic [REG_W-1:0] exp_rd;
    reg_write(pack(up, 1'b1, 1'b0, d));
    check("R2", rd_data, pack(up, 1'b1, 1'b0, d));
    cap = '0; n_rise = 0; gap_bad = 0;
    reg_write(pack(up, 1'b1, 1'b1, d));
    check("R3", {rd_data[16], cs_n}, 2'b10);
    len = 1;
    exp_rd = pack(up, 1'b1, 1'b0, d);
    while (rd_data[16] && len < 10000) begin
      if (mid && len == 5) begin
        wr_en = 1'b1; wr_data = pack(~up, 1'b1, mid_go, d2);
        exp_rd = pack(~up, 1'b1, 1'b0, d2);
      end else wr_en = 1'b0;
      @(negedge clk);
      if (rd_data[16]) len++;
    end
    wr_en = 1'b0;
    check("R7", len, exp_len());
    check("R7", {rd_data[16], cs_n}, 2'b01);
    check("R5", n_rise, 16);
    check("R5", cap, d);
    check("R6", gap_bad, 0);
    check("R6", sclk, 1'b0);
    if (mid) begin
      repeat (3 * CLK_DIV) @(negedge clk);
      check("R8", rd_data, exp_rd);
      check("R8", {cs_n, n_rise[7:0]}, {1'b1, 8'd16});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    n_rise = 0; gap_bad = 0; cap = '0; last_rise = 0;
    repeat (3) @(negedge clk);
    check("R1", {rd_data, cs_n, sclk, mosi}, {32'h0, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {rd_data, cs_n, sclk}, {32'h0, 1'b1, 1'b0});

    // R2: storage of all non-go bits
    reg_write(32'hFFFE_FFFF);
    check("R2", rd_data, 32'hFFFE_FFFF);
    check("R4", cs_n, 1'b1);
    reg_write(32'h0000_0000);

    // R4: go without enable
    n_rise = 0;
    reg_write(pack(14'h2AA, 1'b0, 1'b1, 16'hA5A5));
    check("R4", {rd_data[16], cs_n}, 2'b01);
    repeat (4 * CLK_DIV) @(negedge clk);
    check("R4", {n_rise[7:0], cs_n}, {8'd0, 1'b1});

    // directed words
    transfer(14'h0, 16'h8001, 1'b0, 16'h0, 1'b0);
    transfer(14'h3FFF, 16'hFFFF, 1'b0, 16'h0, 1'b0);
    transfer(14'h1234, 16'h0000, 1'b0, 16'h0, 1'b0);
    // R9: same word, different upper bits
    transfer(14'h0, 16'h5A3C, 1'b0, 16'h0, 1'b0);
    transfer(14'h3C0F, 16'h5A3C, 1'b0, 16'h0, 1'b0);
    check("R9", cap, 16'h5A3C);
    // R8: writes during a transfer
    transfer(14'h0155, 16'hC3A1, 1'b1, 16'h1E2D, 1'b1);
    transfer(14'h02AA, 16'h7E81, 1'b1, 16'hFFFF, 1'b0);

    for (int i = 0; i < 20; i++) begin
      logic [15:0] d;
      logic [13:0] up;
      d  = 16'($urandom);
      up = 14'($urandom);
      transfer(up, d, ($urandom % 3) == 0, 16'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule